// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides where the program counter goes when the core takes a fault, a trap or an interrupt, and where it goes when a handler returns. Each event code maps to a fixed offset, and that offset is added to the handler base register to give the entry address. The low bit of every offset is set, which marks the handler target as privileged. The block also keeps the saved exception address. That is the current PC for a fault, or the PC of the following instruction for a trap. It tracks whether the core runs in handler mode, and it tells the register file when to exchange a fixed group of integer registers with their shadow copies.

On return from a handler, the saved address becomes the new PC. The shadow group is exchanged back, and handler mode is left, only when bit 0 of that address is clear. A return request issued outside handler mode is turned into an unimplemented-opcode fault. After reset the block issues a single redirect to the reset entry point, with handler mode and the shadow group already active.

All outputs are registered. A request sampled at one rising edge shows on the outputs right after that edge.

Top module: `exc_sequencer`

## Requirements
- R1: While reset is asserted, `redirect`, `swapPulse` and `intrArm` are 0, `excAddr` is 0 and `handlerMode` is 1. The first edge after reset is released gives `redirect`=1, `tgtPc`=`palBase`+0x0001 and `tgtNpc`=`tgtPc`+4, with no swap.
- R2: An event with a nonzero `evtCode` redirects to `palBase` plus an offset. The codes and offsets are: 1→0x0401, 2→0x0501, 3→0x0101, 4→0x0201, 5→0x0281, 6→0x0301, 7→0x0381, 8→0x0381, 9→0x0181, 10→0x0181, 11→0x0081, 12→0x0481, 13→0x0581, 14→0x2001, 15→0x0501. In every redirect, `tgtNpc` equals `tgtPc`+4.
- R3: An event stores `curPc`+4 in `excAddr` for code 2 (arithmetic trap) and code 14 (privileged call). It stores `curPc` for every other code.
- R4: An interrupt (code 3) taken while `handlerMode`=1 leaves `excAddr` unchanged and causes no swap.
- R5: An event taken with `handlerMode`=0 pulses `swapPulse` with `swapToShadow`=1 and `swapMask`=0x0200_7F00 (registers 8–14 and 25), and sets `handlerMode`. An event taken in handler mode causes no swap. `swapMask` is 0 whenever there is no swap.
- R6: A return in handler mode redirects to the old `excAddr`, with `tgtNpc` 4 above it, and pulses `intrArm`. If bit 0 of that address is 0, it also pulses `swapPulse` with `swapToShadow`=0 and clears `handlerMode`. If bit 0 is 1, handler mode stays set.
- R7: A return outside handler mode acts as event code 12. It redirects to `palBase`+0x0481, stores `curPc` and swaps the shadow group in. It does not pulse `intrArm`.
- R8: A write through `excWrEn` stores `excWrData` with bit 1 forced to 0. An event that saves an address in the same cycle wins over the write.
- R9: An event with `evtValid`=0 or code 0 has no effect. If an event and a return arrive in the same cycle, the event is taken and the return is dropped.
- R10: `swapErr` rises only when a swap is asked into the state already active. Under any legal input sequence it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event request strobe |
| evtCode | input | 4 | Event code (see R2) |
| curPc | input | AW | PC of the current instruction |
| palBase | input | AW | Handler base register |
| retReq | input | 1 | Return-from-handler request |
| excWrEn | input | 1 | Write strobe for the saved exception address |
| excWrData | input | AW | Write data for the saved exception address |
| redirect | output | 1 | New PC valid this cycle |
| tgtPc | output | AW | New PC |
| tgtNpc | output | AW | New PC + 4 |
| excAddr | output | AW | Saved exception address |
| handlerMode | output | 1 | Core is in handler mode |
| swapPulse | output | 1 | Exchange the shadow registers this cycle |
| swapToShadow | output | 1 | 1: shadow copies go in, 0: they go out |
| swapMask | output | NREG | Registers that take part in the exchange |
| intrArm | output | 1 | Re-enable interrupt checking |
| swapErr | output | 1 | Swap asked into the state already active |

## Verification
The hardest case to reach from the ports is an interrupt that arrives while a handler is already running. To create it, the bench first takes a fault to enter handler mode and then raises code 3 before any return. The second difficult case is a return that must stay in handler mode. To reach it, the bench writes an odd address into the saved register before issuing the return. Both cases also come up in a long random phase, in which events, returns and register writes land in the same cycles as one another. A behavioural reference model is compared with every output on every clock.

// File: rtl/excseq_pkg.sv
package excseq_pkg;

  typedef enum logic [3:0] {
    EV_NONE     = 4'd0,
    EV_MCHK     = 4'd1,
    EV_ARITH    = 4'd2,
    EV_INTR     = 4'd3,
    EV_DTBM_NAT = 4'd4,
    EV_DTBM_PAL = 4'd5,
    EV_ALIGN    = 4'd6,
    EV_DTB_FLT  = 4'd7,
    EV_DTB_ACV  = 4'd8,
    EV_ITB_MISS = 4'd9,
    EV_ITB_FLT  = 4'd10,
    EV_ITB_ACV  = 4'd11,
    EV_UNIMP    = 4'd12,
    EV_FPDIS    = 4'd13,
    EV_PRIV     = 4'd14,
    EV_IOVF     = 4'd15
  } evCode_e;

  localparam int OFFW = 14;
  localparam logic [OFFW-1:0] RESET_OFF = 14'h0001;

  function automatic logic [OFFW-1:0] vecOffset(evCode_e c);
    unique case (c)
      EV_MCHK:                 vecOffset = 14'h0401;
      EV_ARITH, EV_IOVF:       vecOffset = 14'h0501;
      EV_INTR:                 vecOffset = 14'h0101;
      EV_DTBM_NAT:             vecOffset = 14'h0201;
      EV_DTBM_PAL:             vecOffset = 14'h0281;
      EV_ALIGN:                vecOffset = 14'h0301;
      EV_DTB_FLT, EV_DTB_ACV:  vecOffset = 14'h0381;
      EV_ITB_MISS, EV_ITB_FLT: vecOffset = 14'h0181;
      EV_ITB_ACV:              vecOffset = 14'h0081;
      EV_UNIMP:                vecOffset = 14'h0481;
      EV_FPDIS:                vecOffset = 14'h0581;
      EV_PRIV:                 vecOffset = 14'h2001;
      default:                 vecOffset = 14'h0000;
    endcase
  endfunction

  typedef struct packed {
    logic    boot;
    logic    enter;
    evCode_e code;
    logic    saveExc;
    logic    skipInsn;
    logic    swapIn;
    logic    swapOut;
    logic    doRet;
    logic    wrExc;
  } strobes_t;

endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import excseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     evtValid,
  input  evCode_e  evtCode,
  input  logic     retReq,
  input  logic     excWrEn,
  input  logic     excBit0,
  output strobes_t stb,
  output logic     handlerMode
);

  logic bootPend;
  logic evTake, retGood, retBad;
  evCode_e effCode;

  always_comb begin
    evTake  = !bootPend && evtValid && (evtCode != EV_NONE);
    retGood = !bootPend && !evTake && retReq && handlerMode;
    retBad  = !bootPend && !evTake && retReq && !handlerMode;
    effCode = evTake ? evtCode : EV_UNIMP;

    stb          = '0;
    stb.boot     = bootPend;
    stb.enter    = evTake || retBad;
    stb.code     = effCode;
    stb.saveExc  = stb.enter && !(effCode == EV_INTR && handlerMode);
    stb.skipInsn = (effCode == EV_ARITH) || (effCode == EV_PRIV);
    stb.swapIn   = stb.enter && !handlerMode;
    stb.swapOut  = retGood && !excBit0;
    stb.doRet    = retGood;
    stb.wrExc    = excWrEn && !stb.saveExc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootPend    <= 1'b1;
      handlerMode <= 1'b1;
    end else begin
      bootPend <= 1'b0;
      if (stb.swapIn)       handlerMode <= 1'b1;
      else if (stb.swapOut) handlerMode <= 1'b0;
    end
  end

  // R9
  ignore_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bootPend && !retReq && (!evtValid || evtCode == EV_NONE)) |=> $stable(handlerMode));

endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import excseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 32,
  parameter logic [NREG-1:0] SHADOW_MASK = 32'h0200_7F00
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        stb,
  input  logic [AW-1:0]   curPc,
  input  logic [AW-1:0]   palBase,
  input  logic [AW-1:0]   excWrData,
  output logic            redirect,
  output logic [AW-1:0]   tgtPc,
  output logic [AW-1:0]   tgtNpc,
  output logic [AW-1:0]   excAddr,
  output logic            swapPulse,
  output logic            swapToShadow,
  output logic [NREG-1:0] swapMask,
  output logic            intrArm,
  output logic            swapErr
);

  localparam logic [AW-1:0] INSN_BYTES = AW'(4);
  localparam logic [AW-1:0] BIT1_CLR   = ~(AW'(2));

  logic bankIn;
  logic [AW-1:0] entryPc;

  always_comb begin
    if (stb.boot) entryPc = palBase + AW'(RESET_OFF);
    else          entryPc = palBase + AW'(vecOffset(stb.code));
  end

  assign tgtNpc = tgtPc + INSN_BYTES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      redirect     <= 1'b0;
      tgtPc        <= '0;
      excAddr      <= '0;
      swapPulse    <= 1'b0;
      swapToShadow <= 1'b0;
      swapMask     <= '0;
      intrArm      <= 1'b0;
      swapErr      <= 1'b0;
      bankIn       <= 1'b1;
    end else begin
      redirect  <= stb.boot || stb.enter || stb.doRet;
      if (stb.boot || stb.enter) tgtPc <= entryPc;
      else if (stb.doRet)        tgtPc <= excAddr;

      if (stb.saveExc)    excAddr <= stb.skipInsn ? curPc + INSN_BYTES : curPc;
      else if (stb.wrExc) excAddr <= excWrData & BIT1_CLR;

      swapPulse    <= stb.swapIn || stb.swapOut;
      swapToShadow <= stb.swapIn;
      swapMask     <= (stb.swapIn || stb.swapOut) ? SHADOW_MASK : '0;
      intrArm      <= stb.doRet;
      swapErr      <= (stb.swapIn && bankIn) || (stb.swapOut && !bankIn);
      if (stb.swapIn)       bankIn <= 1'b1;
      else if (stb.swapOut) bankIn <= 1'b0;
    end
  end

  // R8
  wr_bit1_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrExc |=> !excAddr[1]);

  // R6
  ret_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.doRet |=> (tgtPc == $past(excAddr)));

endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import excseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtValid,
  input  logic [3:0]      evtCode,
  input  logic [AW-1:0]   curPc,
  input  logic [AW-1:0]   palBase,
  input  logic            retReq,
  input  logic            excWrEn,
  input  logic [AW-1:0]   excWrData,
  output logic            redirect,
  output logic [AW-1:0]   tgtPc,
  output logic [AW-1:0]   tgtNpc,
  output logic [AW-1:0]   excAddr,
  output logic            handlerMode,
  output logic            swapPulse,
  output logic            swapToShadow,
  output logic [NREG-1:0] swapMask,
  output logic            intrArm,
  output logic            swapErr
);

  localparam logic [NREG-1:0] SHADOW_MASK = NREG'(32'h0200_7F00);

  strobes_t stb;

  exc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evtValid    (evtValid),
    .evtCode     (evCode_e'(evtCode)),
    .retReq      (retReq),
    .excWrEn     (excWrEn),
    .excBit0     (excAddr[0]),
    .stb         (stb),
    .handlerMode (handlerMode)
  );

  exc_datapath #(.AW(AW), .NREG(NREG), .SHADOW_MASK(SHADOW_MASK)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .curPc        (curPc),
    .palBase      (palBase),
    .excWrData    (excWrData),
    .redirect     (redirect),
    .tgtPc        (tgtPc),
    .tgtNpc       (tgtNpc),
    .excAddr      (excAddr),
    .swapPulse    (swapPulse),
    .swapToShadow (swapToShadow),
    .swapMask     (swapMask),
    .intrArm      (intrArm),
    .swapErr      (swapErr)
  );

  // R5
  swap_in_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swapPulse && swapToShadow) |-> handlerMode);

  // R4
  intr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtCode == 4'd3 && handlerMode && !excWrEn) |=> $stable(excAddr));

  // R7
  bad_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !handlerMode && (!evtValid || evtCode == 4'd0)) |=> (redirect && handlerMode && !intrArm));

  // R10
  no_swap_err_chk: assert property (@(posedge clk) disable iff (!rstN) !swapErr);

endmodule

// File: tb/sim_exc_sequencer.sv
`timescale 1ns/1ps
module sim_exc_sequencer;
  localparam int AW = 32;
  localparam int NREG = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic [3:0] evtCode = '0;
  logic [AW-1:0] curPc = '0, palBase = 32'h0010_0000, excWrData = '0;
  logic retReq = 1'b0, excWrEn = 1'b0;
  logic redirect, handlerMode, swapPulse, swapToShadow, intrArm, swapErr;
  logic [AW-1:0] tgtPc, tgtNpc, excAddr;
  logic [NREG-1:0] swapMask;

  always #2.5 clk = ~clk;

  exc_sequencer #(.AW(AW), .NREG(NREG)) u0 (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string curTag = "R1";

  // reference model state
  bit mBoot, mHm, mRed, mSwap, mToSh, mArm;
  logic [AW-1:0] mExc, mTgt;

  function automatic logic [AW-1:0] offOf(int c);
    case (c)
      1: return 32'h401;  2: return 32'h501;  3: return 32'h101;
      4: return 32'h201;  5: return 32'h281;  6: return 32'h301;
      7: return 32'h381;  8: return 32'h381;  9: return 32'h181;
      10: return 32'h181; 11: return 32'h081; 12: return 32'h481;
      13: return 32'h581; 14: return 32'h2001; 15: return 32'h501;
      default: return 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mBoot = 1; mHm = 1; mRed = 0; mSwap = 0; mToSh = 0; mArm = 0;
    mExc = '0; mTgt = '0;
  endtask

  task automatic modelStep();
    bit ev, ret, saved;
    int c;
    logic [AW-1:0] oldExc;
    if (!rstN) begin modelReset(); return; end
    mRed = 0; mSwap = 0; mToSh = 0; mArm = 0; saved = 0;
    oldExc = mExc;
    ev  = !mBoot && evtValid && evtCode != 0;
    ret = !mBoot && !ev && retReq;
    if (mBoot) begin
      mRed = 1; mTgt = palBase + 1; mBoot = 0;
    end else if (ev || (ret && !mHm)) begin
      c = ev ? int'(evtCode) : 12;
      mRed = 1; mTgt = palBase + offOf(c);
      if (!(c == 3 && mHm)) begin
        saved = 1;
        mExc = (c == 2 || c == 14) ? curPc + 4 : curPc;
      end
      if (!mHm) begin mSwap = 1; mToSh = 1; mHm = 1; end
    end else if (ret) begin
      mRed = 1; mTgt = oldExc; mArm = 1;
      if (!oldExc[0]) begin mSwap = 1; mHm = 0; end
    end
    if (excWrEn && !saved) mExc = excWrData & ~32'h2;
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("redirect", 64'(redirect), 64'(mRed), curTag);
    if (mRed) begin
      chk("tgtPc", 64'(tgtPc), 64'(mTgt), curTag);
      chk("tgtNpc", 64'(tgtNpc), 64'(mTgt + 4), curTag);
    end
    chk("excAddr", 64'(excAddr), 64'(mExc), curTag);
    chk("handlerMode", 64'(handlerMode), 64'(mHm), curTag);
    chk("swapPulse", 64'(swapPulse), 64'(mSwap), curTag);
    if (mSwap) chk("swapToShadow", 64'(swapToShadow), 64'(mToSh), curTag);
    chk("swapMask", 64'(swapMask), mSwap ? 64'h0200_7F00 : 64'h0, curTag);
    chk("intrArm", 64'(intrArm), 64'(mArm), curTag);
    chk("swapErr", 64'(swapErr), 64'h0, "R10");
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    evtValid = 0; retReq = 0; excWrEn = 0;
  endtask

  task automatic fire(int c, logic [AW-1:0] pc);
    evtValid = 1; evtCode = 4'(c); curPc = pc; cyc();
  endtask

  task automatic wrExc(logic [AW-1:0] d);
    excWrEn = 1; excWrData = d; cyc();
  endtask

  task automatic doRet();
    retReq = 1; cyc();
  endtask

  initial begin
    modelReset();
    curTag = "R1";
    repeat (3) begin @(negedge clk); compareAll(); end
    rstN = 1;
    cyc();
    chk("boot target", 64'(tgtPc), 64'(32'h0010_0001), "R1");
    cyc();

    curTag = "R6";
    doRet();
    chk("left handler mode", 64'(handlerMode), 64'h0, "R6");

    for (int c = 1; c < 16; c++) begin
      curTag = (c == 2 || c == 14) ? "R3" : "R2";
      fire(c, 32'h0000_4000 + 32'(c * 16));
      curTag = "R5";
      fire(6, 32'h0000_8000);
      curTag = "R6";
      wrExc(32'h0000_9000 + 32'(c * 8));
      doRet();
    end

    curTag = "R4";
    fire(6, 32'h0000_A000);
    fire(3, 32'h0000_B000);
    chk("intr keeps excAddr", 64'(excAddr), 64'(32'h0000_A000), "R4");

    curTag = "R6";
    wrExc(32'h0000_C001);
    doRet();
    chk("odd return stays handler", 64'(handlerMode), 64'h1, "R6");
    wrExc(32'h0000_C000);
    doRet();

    curTag = "R8";
    palBase = 32'h0230_0000;
    wrExc(32'hFFFF_FFFF);
    chk("bit1 forced low", 64'(excAddr[1]), 64'h0, "R8");
    excWrEn = 1; excWrData = 32'h0000_0010;
    fire(1, 32'h0000_D000);
    chk("event beats write", 64'(excAddr), 64'(32'h0000_D000), "R8");
    wrExc(32'h0000_E000);
    doRet();

    curTag = "R7";
    curPc = 32'h0000_F000;
    doRet();
    chk("bad return vector", 64'(tgtPc), 64'(32'h0230_0481), "R7");
    wrExc(32'h0000_F100);
    doRet();

    curTag = "R9";
    evtValid = 1; evtCode = 0; cyc();
    evtValid = 0; evtCode = 4'd5; cyc();
    evtValid = 1; evtCode = 4'd9; retReq = 1; curPc = 32'h0000_1230; cyc();
    wrExc(32'h0000_1300);
    doRet();

    curTag = "R2";
    for (int i = 0; i < 600; i++) begin
      evtValid  = ($urandom_range(0, 5) == 0);
      evtCode   = 4'($urandom_range(0, 15));
      retReq    = ($urandom_range(0, 4) == 0);
      excWrEn   = ($urandom_range(0, 3) == 0);
      excWrData = $urandom;
      curPc     = $urandom & 32'hFFFF_FFFC;
      if (i % 100 == 0) palBase = $urandom & 32'hFFFF_0000;
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule